// File: doc/BRIEF.md
# Parity Error First/Next Logger and Notification Router

The block gathers four single-cycle parity error pulses from a posted write buffer datapath and records them. Event 0 is a parity error on data read from DRAM into the buffer. Event 1 is a parity error on a system-bus or I/O write into the buffer. Event 2 is a parity error on buffer data sent out to the system bus. Event 3 is a parity error when the buffer is flushed to DRAM. All four are uncorrectable and are rolled up as non-fatal.

A one-flag first-error register holds the earliest logged event. A next-error register records one further occurrence of each event type. Four notification levels are produced: SCI, SMI, SERR and MCERR. For each level and each event, software picks with its own enable bit whether that event drives that level. A per-event mask suppresses both logging and reporting. SERR also requires a global enable bit. Two non-fatal summary levels tell an upstream aggregator whether a first or a next flag is pending.

Software reaches the block through a plain single-cycle register write port with a combinational read port.

Top module: `perr_log_router`

## Requirements
- R1: After reset both flag registers read 0, the mask register reads 0x0F (all events masked), every command register and the SERR enable read 0, and all six outputs are low.
- R2: When the first-error register is empty and one or more unmasked events pulse, only the lowest-numbered of them is set in the first-error register (bit i = event i). The rest set their bits in the next-error register.
- R3: While the first-error register holds a flag, new unmasked events set only their next-error bits and leave the first-error register unchanged.
- R4: An event whose mask bit is 1 sets no flag. A logged flag whose mask bit is later set drives no notification or summary output.
- R5: Flags are cleared by writing 1 to their bit at address 0 (first) or address 1 (next). Bits written 0 are unchanged. When a clear of the first-error register and an event occur in the same cycle, the event is judged against the cleared register.
- R6: sci_o, smi_o and mcerr_o are high exactly while some unmasked flag, in either register, has its enable bit set in the command register at address 3, 4 or 6 respectively.
- R7: serr_o follows the same rule using the command register at address 5, and is additionally gated by bit 0 of address 7.
- R8: gnf_first_o is high while the first-error register holds an unmasked flag. gnf_next_o is high while the next-error register holds an unmasked flag.
- R9: Register map: 0 first, 1 next, 2 mask, 3 SCI cmd, 4 SMI cmd, 5 SERR cmd, 6 MCERR cmd, 7 global control (bit 0 = SERR enable). Bit i of each per-event register belongs to event i, and unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 4 | Parity error event pulses, bit i = event i |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| sci_o | output | 1 | SCI notification level |
| smi_o | output | 1 | SMI notification level |
| serr_o | output | 1 | SERR notification level |
| mcerr_o | output | 1 | MCERR notification level |
| gnf_first_o | output | 1 | Non-fatal first-error summary |
| gnf_next_o | output | 1 | Non-fatal next-error summary |

## Verification
Two operations can fall in the same cycle: a software write-1-to-clear of a flag register, and a new event pulse. The bench drives a clear of the first-error register in the same cycle as an event of the same type and of other types. It also drives a write of zeros to the next-error register together with an event. It then reads both registers back and requires that the event was placed against the register contents after the clear. Simultaneous multi-event pulses with an empty first-error register are judged the same way, by reading where each bit landed.

// File: rtl/perr_pkg.sv
package perr_pkg;
    localparam int EV_N  = 4;
    localparam int CLS_N = 4;
    localparam int AW    = 3;

    localparam logic [AW-1:0] A_FIRST = 3'd0;
    localparam logic [AW-1:0] A_NEXT  = 3'd1;
    localparam logic [AW-1:0] A_MASK  = 3'd2;
    localparam logic [AW-1:0] A_CMD0  = 3'd3;
    localparam logic [AW-1:0] A_GCTL  = 3'd7;

    // notification class indices, command register at A_CMD0 + index
    localparam int C_SCI   = 0;
    localparam int C_SMI   = 1;
    localparam int C_SERR  = 2;
    localparam int C_MCERR = 3;

    typedef struct packed {
        logic [EV_N-1:0] first;
        logic [EV_N-1:0] next;
    } flags_t;

    typedef struct packed {
        logic [EV_N-1:0]            mask;
        logic [CLS_N-1:0][EV_N-1:0] cmd;
        logic                       serr_en;
    } cfg_t;
endpackage

// File: rtl/perr_cfg.sv
module perr_cfg
    import perr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg_q
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (addr == A_MASK) cfg_d.mask = wdata[EV_N-1:0];
            if (addr == A_GCTL) cfg_d.serr_en = wdata[0];
            for (int k = 0; k < CLS_N; k++) begin
                if (addr == A_CMD0 + AW'(k)) cfg_d.cmd[k] = wdata[EV_N-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask    <= '1;
            cfg_q.cmd     <= '0;
            cfg_q.serr_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/perr_capture.sv
module perr_capture
    import perr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] ev,
    input  logic [EV_N-1:0] mask,
    input  logic [EV_N-1:0] clr_first,
    input  logic [EV_N-1:0] clr_next,
    output flags_t          flags_q
);
    flags_t          flags_d;
    logic [EV_N-1:0] hit;
    logic [EV_N-1:0] f_keep;
    logic [EV_N-1:0] n_keep;
    logic [EV_N-1:0] pick;

    always_comb begin
        hit    = ev & ~mask;
        f_keep = flags_q.first & ~clr_first;
        n_keep = flags_q.next & ~clr_next;
        pick   = hit & (~hit + EV_N'(1));
        if (f_keep == '0 && hit != '0) begin
            flags_d.first = pick;
            flags_d.next  = n_keep | (hit & ~pick);
        end else begin
            flags_d.first = f_keep;
            flags_d.next  = n_keep | hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/perr_route.sv
module perr_route
    import perr_pkg::*;
(
    input  flags_t           flags,
    input  cfg_t             cfg,
    output logic [CLS_N-1:0] notify,
    output logic             sum_first,
    output logic             sum_next
);
    logic [EV_N-1:0] live;

    always_comb begin
        live      = (flags.first | flags.next) & ~cfg.mask;
        sum_first = |(flags.first & ~cfg.mask);
        sum_next  = |(flags.next & ~cfg.mask);
    end

    for (genvar k = 0; k < CLS_N; k++) begin : g_cls
        if (k == C_SERR) begin : g_gated
            assign notify[k] = cfg.serr_en & (|(live & cfg.cmd[k]));
        end else begin : g_plain
            assign notify[k] = |(live & cfg.cmd[k]);
        end
    end
endmodule

// File: rtl/perr_log_router.sv
module perr_log_router
    import perr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] ev_i,
    input  logic            reg_wr_en,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            sci_o,
    output logic            smi_o,
    output logic            serr_o,
    output logic            mcerr_o,
    output logic            gnf_first_o,
    output logic            gnf_next_o
);
    cfg_t             cfg_q;
    flags_t           flags_q;
    logic [EV_N-1:0]  clr_first;
    logic [EV_N-1:0]  clr_next;
    logic [CLS_N-1:0] notify;
    logic [EV_N-1:0]  rd_sel;

    always_comb begin
        clr_first = (reg_wr_en && reg_addr == A_FIRST) ? reg_wdata[EV_N-1:0] : '0;
        clr_next  = (reg_wr_en && reg_addr == A_NEXT)  ? reg_wdata[EV_N-1:0] : '0;
    end

    perr_cfg #(.DW(DW)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg_q (cfg_q)
    );

    perr_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_i),
        .mask      (cfg_q.mask),
        .clr_first (clr_first),
        .clr_next  (clr_next),
        .flags_q   (flags_q)
    );

    perr_route u_route (
        .flags     (flags_q),
        .cfg       (cfg_q),
        .notify    (notify),
        .sum_first (gnf_first_o),
        .sum_next  (gnf_next_o)
    );

    assign sci_o   = notify[C_SCI];
    assign smi_o   = notify[C_SMI];
    assign serr_o  = notify[C_SERR];
    assign mcerr_o = notify[C_MCERR];

    always_comb begin
        rd_sel = '0;
        case (reg_addr)
            A_FIRST: rd_sel = flags_q.first;
            A_NEXT:  rd_sel = flags_q.next;
            A_MASK:  rd_sel = cfg_q.mask;
            A_GCTL:  rd_sel = EV_N'(cfg_q.serr_en);
            default: begin
                for (int k = 0; k < CLS_N; k++) begin
                    if (reg_addr == A_CMD0 + AW'(k)) rd_sel = cfg_q.cmd[k];
                end
            end
        endcase
        reg_rdata = DW'(rd_sel);
    end
endmodule

// File: rtl/perr_log_router_chk.sv
module perr_log_router_chk
    import perr_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [EV_N-1:0] ev_i,
    input logic            reg_wr_en,
    input flags_t          flags_q,
    input cfg_t            cfg_q,
    input logic            serr_o,
    input logic            sci_o
);
    // R2
    one_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags_q.first));

    // R2
    first_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.first == '0 && (ev_i & ~cfg_q.mask) != '0 && !reg_wr_en)
        |=> flags_q.first != '0);

    // R3
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.first != '0 && !reg_wr_en) |=> $stable(flags_q.first));

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_i & ~cfg_q.mask) == '0 && !reg_wr_en)
        |=> ($stable(flags_q.first) && $stable(flags_q.next)));

    // R7
    serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> cfg_q.serr_en);

    // R6
    sci_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_o |-> ((flags_q.first | flags_q.next) != '0));
endmodule

bind perr_log_router perr_log_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev_i),
    .reg_wr_en (reg_wr_en),
    .flags_q   (flags_q),
    .cfg_q     (cfg_q),
    .serr_o    (serr_o),
    .sci_o     (sci_o)
);

// File: tb/sim_perr_log_router.sv
`timescale 1ns/100ps
module sim_perr_log_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ev_i = '0;
    logic       reg_wr_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic sci_o, smi_o, serr_o, mcerr_o, gnf_first_o, gnf_next_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    perr_log_router u0 (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sci_o(sci_o), .smi_o(smi_o), .serr_o(serr_o), .mcerr_o(mcerr_o),
        .gnf_first_o(gnf_first_o), .gnf_next_o(gnf_next_o)
    );

    // vector: wen(1) addr(3) wdata(8) ev(4) exp_first(4) exp_next(4)
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00, 4'b0110, 4'b0010, 4'b0100}, // R2 two at once
        {1'b0, 3'd0, 8'h00, 4'b0010, 4'b0010, 4'b0110}, // R3 repeat type
        {1'b0, 3'd0, 8'h00, 4'b1000, 4'b0010, 4'b1110}, // R3
        {1'b1, 3'd0, 8'h02, 4'b0000, 4'b0000, 4'b1110}, // R5 clear first
        {1'b0, 3'd0, 8'h00, 4'b1001, 4'b0001, 4'b1110}, // R2 refill
        {1'b1, 3'd1, 8'h0E, 4'b0000, 4'b0001, 4'b0000}, // R5 clear next
        {1'b1, 3'd0, 8'h01, 4'b0100, 4'b0100, 4'b0000}, // R5 clear+event
        {1'b1, 3'd0, 8'h04, 4'b0100, 4'b0100, 4'b0000}, // R5 same type
        {1'b1, 3'd0, 8'h04, 4'b0000, 4'b0000, 4'b0000}, // R5
        {1'b0, 3'd0, 8'h00, 4'b1111, 4'b0001, 4'b1110}, // R2 all four
        {1'b1, 3'd0, 8'hFF, 4'b0000, 4'b0000, 4'b1110}, // R5
        {1'b1, 3'd1, 8'h00, 4'b0001, 4'b0001, 4'b1110}  // R5 zeros keep
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic [3:0] e);
        reg_wr_en = w; reg_addr = a; reg_wdata = d; ev_i = e;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; ev_i = '0;
    endtask

    task automatic outs(input string req, input logic [5:0] exp);
        chk(req, {2'b0, sci_o, smi_o, serr_o, mcerr_o, gnf_first_o, gnf_next_o}, {2'b0, exp});
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, d); chk("R1 first", d, 8'h00);
        rd(3'd1, d); chk("R1 next", d, 8'h00);
        rd(3'd2, d); chk("R1 mask", d, 8'h0F);
        for (int a = 3; a < 8; a++) begin
            rd(3'(a), d); chk("R1 cmd", d, 8'h00);
        end
        outs("R1 outputs", 6'b000000);
        // R4 masked event after reset logs nothing
        cyc(1'b0, 3'd0, 8'h00, 4'b1111);
        rd(3'd0, d); chk("R4 masked first", d, 8'h00);
        rd(3'd1, d); chk("R4 masked next", d, 8'h00);

        // unmask all, walk vectors (R2 R3 R5)
        cyc(1'b1, 3'd2, 8'h00, 4'b0000);
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][23], VEC[i][22:20], VEC[i][19:12], VEC[i][11:8]);
            rd(3'd0, d); chk("R2/R3/R5 vec first", d, {4'b0, VEC[i][7:4]});
            rd(3'd1, d); chk("R2/R3/R5 vec next", d, {4'b0, VEC[i][3:0]});
        end

        // clear all, then routing R6 R7 R8
        cyc(1'b1, 3'd0, 8'h0F, 4'b0000);
        cyc(1'b1, 3'd1, 8'h0F, 4'b0000);
        cyc(1'b1, 3'd3, 8'h01, 4'b0000);
        cyc(1'b1, 3'd4, 8'h02, 4'b0000);
        cyc(1'b1, 3'd5, 8'h04, 4'b0000);
        cyc(1'b1, 3'd6, 8'h08, 4'b0000);
        rd(3'd4, d); chk("R9 smi cmd readback", d, 8'h02);
        outs("R6 idle", 6'b000000);
        cyc(1'b0, 3'd0, 8'h00, 4'b0001);
        outs("R6 R8 sci from first", 6'b100010);
        cyc(1'b0, 3'd0, 8'h00, 4'b0100);
        outs("R7 serr gated off", 6'b100011);
        cyc(1'b1, 3'd7, 8'h01, 4'b0000);
        outs("R7 serr enabled", 6'b101011);
        rd(3'd7, d); chk("R9 gctl readback", d, 8'h01);
        cyc(1'b0, 3'd0, 8'h00, 4'b1010);
        outs("R6 smi mcerr via next", 6'b111111);
        cyc(1'b1, 3'd2, 8'h04, 4'b0000);
        outs("R4 mask hides serr", 6'b110111);
        cyc(1'b1, 3'd2, 8'h0F, 4'b0000);
        outs("R4 R8 all masked", 6'b000000);
        rd(3'd0, d); chk("R4 flag kept under mask", d, 8'h01);
        // R4 masked event does not log
        cyc(1'b1, 3'd0, 8'h0F, 4'b0000);
        cyc(1'b1, 3'd1, 8'h0F, 4'b0000);
        cyc(1'b1, 3'd2, 8'h04, 4'b0000);
        cyc(1'b0, 3'd0, 8'h00, 4'b0100);
        rd(3'd0, d); chk("R4 masked ev first", d, 8'h00);
        rd(3'd1, d); chk("R4 masked ev next", d, 8'h00);
        outs("R4 masked outputs", 6'b000000);
        cyc(1'b0, 3'd0, 8'h00, 4'b0010);
        outs("R8 only first summary", 6'b010010);
        finish_up();
    end
endmodule